// File: doc/BRIEF.md
# Fast-Segment Row Cache Controller

This controller belongs in the command path of a memory controller for a DRAM array. In that array, an isolation switch splits each bitline into a short fast segment and a long slow segment. Rows of the fast segment act as an inclusive cache for rows of the slow segment in the same subarray. For every subarray, the controller keeps a tag for each fast row. On every row request it looks up the addressed subarray in the same cycle. It answers with the physical row to activate: the fast copy on a hit, the slow original on a miss.

Physical rows inside a subarray are numbered with the fast rows first (0 to FAST_ROWS-1). Slow row `r` is then at FAST_ROWS+r. The controller closes each row after use, so each request is a fresh activate. A request is either a normal access or a wait report. A wait report says that an earlier access to that row made a later request wait.

A selectable policy decides which misses cause a fill and which fast row is given up:
- plain least-recently-used,
- wait-driven, where only rows reported as causing waits are filled,
- benefit-driven, using a saturating 8-bit score per fast row.

A fill runs as an in-array copy. The controller first activates the slow source row and then the fast destination row. After that it stays busy for a fixed number of extra cycles, which stands for the cost of the copy.

Top module: `tlc_row_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid` is 0. Every tag is invalid. Under either LRU-ordered policy, fills land on fast rows 0, 1, 2, … in that order.
- R2: In the same cycle as the request, `rsp_hit` is 1 exactly when the addressed subarray holds `req_row` in a valid fast row. `rsp_row` is then that fast row's index. On a miss, `rsp_row` is FAST_ROWS+`req_row`.
- R3: Tags are kept per subarray. A row cached in one subarray misses in every other subarray.
- R4: With `pol_sel` 0, and also 3, every access miss fills the least recently used fast row. An access hit makes its row the most recently used. Wait reports never fill.
- R5: With `pol_sel` 1, access misses do not fill. A wait report that misses fills the least recently used fast row. A wait-report hit leaves the recency order unchanged.
- R6: With `pol_sel` 2, both access misses and wait-report misses fill. The victim is the lowest-indexed invalid fast row if one exists. Otherwise it is the row with the lowest benefit, with ties going to the lower index. A filled row starts at benefit 0.
- R7: Under every policy, an access hit or a wait-report hit raises that row's benefit by 1. When an increment would reach 255, every benefit in that subarray is halved (rounding down), and the incremented row becomes 127.
- R8: A fill is accepted at a clock edge. In the next cycle the controller shows `cmd_valid`=1, `cmd_to_fast`=0, and `cmd_row`=FAST_ROWS+slow row. In the cycle after that it shows `cmd_valid`=1, `cmd_to_fast`=1, and `cmd_row`=victim index. `req_ready` stays 0 from the accepting edge for 2+MIG_EXTRA cycles. A request presented while `req_ready` is 0 is not taken.
- R9: Caching is inclusive. After a fill, the filled slow row hits at the victim index. The row that previously occupied that fast row now misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 2 | Policy: 0 LRU, 1 wait-driven, 2 benefit-driven, 3 same as 0; change only while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high together with `req_valid` |
| req_is_wait | input | 1 | 1 = wait report, 0 = normal access |
| req_sub | input | SUB_W | Subarray index |
| req_row | input | SLOW_W | Slow-segment row index |
| rsp_hit | output | 1 | Lookup hit for the presented request |
| rsp_row | output | PHYS_W | Physical row to activate |
| mig_busy | output | 1 | Fill sequence in progress |
| cmd_valid | output | 1 | Copy-activate command present |
| cmd_to_fast | output | 1 | 0 = source slow activate, 1 = destination fast activate |
| cmd_sub | output | SUB_W | Subarray of the copy |
| cmd_row | output | PHYS_W | Physical row of the copy activate |

## Verification
Under the benefit policy, a single hit can raise one row's score to saturation. The halving of the whole subarray then happens in the same cycle. Likewise, a fill must take its victim and also reorder recency within one cycle.

The bench provokes the saturation case directly. It builds a subarray with scores 4, 5 and 6 on three rows and drives one row through 255 hits. The halved scores give a different victim than unhalved scores would, so the next miss's destination command shows whether both updates landed in the same cycle. A reference model in the bench, written with timestamps and plain score arithmetic, judges fills and their recency under long mixed sweeps across every policy.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    POL_LRU     = 2'd0,
    POL_WAIT    = 2'd1,
    POL_BENEFIT = 2'd2,
    POL_ALT_LRU = 2'd3
  } pol_e;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_SRC  = 2'd1,
    MS_DST  = 2'd2,
    MS_HOLD = 2'd3
  } mig_st_e;

  // physical row of a slow-segment row: fast rows come first in a subarray
  function automatic int unsigned slow_phys(int unsigned fast_rows, int unsigned slow_idx);
    return fast_rows + slow_idx;
  endfunction

  function automatic logic fills_on_miss(pol_e p);
    return p != POL_WAIT;
  endfunction

  function automatic logic fills_on_wait(pol_e p);
    return (p == POL_WAIT) || (p == POL_BENEFIT);
  endfunction

endpackage

// File: rtl/tlc_tag_match.sv
module tlc_tag_match #(
  parameter int unsigned FAST_ROWS = 32,
  parameter int unsigned SLOW_W    = 9,
  parameter int unsigned FAST_W    = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [FAST_ROWS-1:0]                 vld_i,
  input  logic [FAST_ROWS-1:0][SLOW_W-1:0]     tag_i,
  input  logic [SLOW_W-1:0]                    row_i,
  output logic                                 hit_o,
  output logic [FAST_W-1:0]                    idx_o
);

  logic [FAST_ROWS-1:0] match;

  for (genvar g = 0; g < FAST_ROWS; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (tag_i[g] == row_i);
  end

  always_comb begin
    idx_o = '0;
    for (int j = FAST_ROWS - 1; j >= 0; j--) begin
      if (match[j]) idx_o = FAST_W'(j);
    end
  end

  assign hit_o = |match;

  // R2: a slow row never sits in two fast rows of one subarray
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/tlc_victim_pick.sv
module tlc_victim_pick import tlc_pkg::*; #(
  parameter int unsigned FAST_ROWS = 32,
  parameter int unsigned FAST_W    = 5,
  parameter int unsigned BEN_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  pol_e                              pol_i,
  input  logic [FAST_ROWS-1:0]              vld_i,
  input  logic [FAST_ROWS-1:0][FAST_W-1:0]  age_i,
  input  logic [FAST_ROWS-1:0][BEN_W-1:0]   ben_i,
  output logic [FAST_W-1:0]                 victim_o
);

  logic [FAST_W-1:0] lru_idx;
  logic [FAST_W-1:0] best_idx;
  logic [BEN_W:0]    best_key;

  // oldest entry carries the highest age
  always_comb begin
    lru_idx = '0;
    for (int j = 0; j < FAST_ROWS; j++) begin
      if (age_i[j] == FAST_W'(FAST_ROWS - 1)) lru_idx = FAST_W'(j);
    end
  end

  // key {valid, benefit}: invalid rows win, then lowest score, then lowest index
  always_comb begin
    best_idx = '0;
    best_key = {vld_i[0], ben_i[0]};
    for (int j = 1; j < FAST_ROWS; j++) begin
      if ({vld_i[j], ben_i[j]} < best_key) begin
        best_key = {vld_i[j], ben_i[j]};
        best_idx = FAST_W'(j);
      end
    end
  end

  assign victim_o = (pol_i == POL_BENEFIT) ? best_idx : lru_idx;

  // R6: with a free fast row present, the benefit policy never displaces a valid one
  p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_i == POL_BENEFIT && !(&vld_i)) |-> !vld_i[victim_o]);

endmodule

// File: rtl/tlc_mig_seq.sv
module tlc_mig_seq import tlc_pkg::*; #(
  parameter int unsigned FAST_ROWS = 32,
  parameter int unsigned SUB_W     = 3,
  parameter int unsigned SLOW_W    = 9,
  parameter int unsigned FAST_W    = 5,
  parameter int unsigned PHYS_W    = 9,
  parameter int unsigned MIG_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [SLOW_W-1:0] slow_i,
  input  logic [FAST_W-1:0] fast_i,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output logic              cmd_to_fast_o,
  output logic [SUB_W-1:0]  cmd_sub_o,
  output logic [PHYS_W-1:0] cmd_row_o
);

  localparam int unsigned CNT_W = (MIG_EXTRA > 0) ? $clog2(MIG_EXTRA + 1) : 1;

  mig_st_e           st_q;
  logic [SUB_W-1:0]  sub_q;
  logic [SLOW_W-1:0] src_q;
  logic [FAST_W-1:0] dst_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      sub_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        MS_IDLE: if (start_i) begin
          st_q  <= MS_SRC;
          sub_q <= sub_i;
          src_q <= slow_i;
          dst_q <= fast_i;
        end
        MS_SRC:  st_q <= MS_DST;
        MS_DST: begin
          cnt_q <= CNT_W'(MIG_EXTRA);
          st_q  <= (MIG_EXTRA == 0) ? MS_IDLE : MS_HOLD;
        end
        MS_HOLD: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= MS_IDLE;
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != MS_IDLE);
  assign cmd_valid_o   = (st_q == MS_SRC) || (st_q == MS_DST);
  assign cmd_to_fast_o = (st_q == MS_DST);
  assign cmd_sub_o     = sub_q;
  assign cmd_row_o     = (st_q == MS_DST) ? PHYS_W'(dst_q)
                                          : PHYS_W'(slow_phys(FAST_ROWS, int'(src_q)));

  // R8: source activate is always followed by the destination activate of the same subarray
  p_src_then_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_to_fast_o) |=> (cmd_valid_o && cmd_to_fast_o && $stable(cmd_sub_o)));

  // R8: a new fill is only launched while no copy is in flight
  p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

endmodule

// File: rtl/tlc_row_cache.sv
module tlc_row_cache import tlc_pkg::*; #(
  parameter int unsigned NUM_SUB   = 8,
  parameter int unsigned FAST_ROWS = 32,
  parameter int unsigned SLOW_ROWS = 480,
  parameter int unsigned BEN_W     = 8,
  parameter int unsigned MIG_EXTRA = 3,
  localparam int unsigned SUB_W    = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int unsigned SLOW_W   = $clog2(SLOW_ROWS),
  localparam int unsigned PHYS_W   = $clog2(FAST_ROWS + SLOW_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pol_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_wait,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [SLOW_W-1:0] req_row,
  output logic              rsp_hit,
  output logic [PHYS_W-1:0] rsp_row,
  output logic              mig_busy,
  output logic              cmd_valid,
  output logic              cmd_to_fast,
  output logic [SUB_W-1:0]  cmd_sub,
  output logic [PHYS_W-1:0] cmd_row
);

  localparam int unsigned FAST_W  = $clog2(FAST_ROWS);
  localparam int unsigned BEN_MAX = (1 << BEN_W) - 1;

  logic [NUM_SUB-1:0][FAST_ROWS-1:0]             vld_q;
  logic [NUM_SUB-1:0][FAST_ROWS-1:0][SLOW_W-1:0] tag_q;
  logic [NUM_SUB-1:0][FAST_ROWS-1:0][BEN_W-1:0]  ben_q;
  logic [NUM_SUB-1:0][FAST_ROWS-1:0][FAST_W-1:0] age_q;

  function automatic logic [FAST_W-1:0] aged(logic [FAST_W-1:0] a, logic [FAST_W-1:0] touched);
    return (a < touched) ? a + 1'b1 : a;
  endfunction

  function automatic logic [BEN_W-1:0] halve(logic [BEN_W-1:0] b);
    return b >> 1;
  endfunction

  pol_e              pol;
  logic              lk_hit;
  logic [FAST_W-1:0] lk_idx;
  logic [FAST_W-1:0] vic_idx;
  logic              seq_busy;
  logic              take;
  logic              fill_go;
  logic              bump_go;
  logic              touch_go;
  logic [FAST_W-1:0] touch_idx;
  logic [BEN_W-1:0]  bump_val;
  logic              bump_sat;

  assign pol = pol_e'(pol_sel);

  tlc_tag_match #(.FAST_ROWS(FAST_ROWS), .SLOW_W(SLOW_W), .FAST_W(FAST_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (vld_q[req_sub]),
    .tag_i (tag_q[req_sub]),
    .row_i (req_row),
    .hit_o (lk_hit),
    .idx_o (lk_idx)
  );

  tlc_victim_pick #(.FAST_ROWS(FAST_ROWS), .FAST_W(FAST_W), .BEN_W(BEN_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol_i    (pol),
    .vld_i    (vld_q[req_sub]),
    .age_i    (age_q[req_sub]),
    .ben_i    (ben_q[req_sub]),
    .victim_o (vic_idx)
  );

  // named internal events
  assign req_ready = !seq_busy;
  assign take      = req_valid && req_ready;
  assign fill_go   = take && !lk_hit && (req_is_wait ? fills_on_wait(pol) : fills_on_miss(pol));
  assign bump_go   = take && lk_hit;
  assign touch_go  = fill_go || (take && lk_hit && !req_is_wait);
  assign touch_idx = fill_go ? vic_idx : lk_idx;
  assign bump_val  = ben_q[req_sub][lk_idx] + BEN_W'(1);
  assign bump_sat  = (bump_val == BEN_W'(BEN_MAX));

  tlc_mig_seq #(
    .FAST_ROWS (FAST_ROWS),
    .SUB_W     (SUB_W),
    .SLOW_W    (SLOW_W),
    .FAST_W    (FAST_W),
    .PHYS_W    (PHYS_W),
    .MIG_EXTRA (MIG_EXTRA)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (fill_go),
    .sub_i         (req_sub),
    .slow_i        (req_row),
    .fast_i        (vic_idx),
    .busy_o        (seq_busy),
    .cmd_valid_o   (cmd_valid),
    .cmd_to_fast_o (cmd_to_fast),
    .cmd_sub_o     (cmd_sub),
    .cmd_row_o     (cmd_row)
  );

  assign mig_busy = seq_busy;
  assign rsp_hit  = lk_hit;
  assign rsp_row  = lk_hit ? PHYS_W'(lk_idx) : PHYS_W'(slow_phys(FAST_ROWS, int'(req_row)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SUB; s++) begin
        for (int j = 0; j < FAST_ROWS; j++) begin
          vld_q[s][j] <= 1'b0;
          tag_q[s][j] <= '0;
          ben_q[s][j] <= '0;
          age_q[s][j] <= FAST_W'(FAST_ROWS - 1 - j);
        end
      end
    end else begin
      for (int j = 0; j < FAST_ROWS; j++) begin
        if (bump_go) begin
          if (bump_sat)
            ben_q[req_sub][j] <= (j == int'(lk_idx)) ? halve(BEN_W'(BEN_MAX)) : halve(ben_q[req_sub][j]);
          else if (j == int'(lk_idx))
            ben_q[req_sub][j] <= bump_val;
        end
        if (touch_go)
          age_q[req_sub][j] <= (j == int'(touch_idx)) ? '0
                              : aged(age_q[req_sub][j], age_q[req_sub][touch_idx]);
        if (fill_go && (j == int'(vic_idx))) begin
          vld_q[req_sub][j] <= 1'b1;
          tag_q[req_sub][j] <= req_row;
          ben_q[req_sub][j] <= '0;
        end
      end
    end
  end

  logic any_ben_full;
  always_comb begin
    any_ben_full = 1'b0;
    for (int s = 0; s < NUM_SUB; s++)
      for (int j = 0; j < FAST_ROWS; j++)
        if (ben_q[s][j] == BEN_W'(BEN_MAX)) any_ben_full = 1'b1;
  end

  // R7: saturation is resolved by halving in the same update, never stored
  p_ben_never_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ben_full);

  // R8: a copy sequence starts only from an accepted request that missed
  p_fill_from_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(take && !lk_hit));

endmodule

// File: tb/tlc_row_cache_tb.sv
module tlc_row_cache_tb;

  localparam int NS = 2;
  localparam int F  = 4;
  localparam int SR = 12;
  localparam int E  = 2;
  localparam int SUB_W  = 1;
  localparam int SLOW_W = 4;
  localparam int PHYS_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        pol_sel = 2'd0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_is_wait = 1'b0;
  logic [SUB_W-1:0]  req_sub = '0;
  logic [SLOW_W-1:0] req_row = '0;
  logic              rsp_hit;
  logic [PHYS_W-1:0] rsp_row;
  logic              mig_busy;
  logic              cmd_valid;
  logic              cmd_to_fast;
  logic [SUB_W-1:0]  cmd_sub;
  logic [PHYS_W-1:0] cmd_row;

  tlc_row_cache #(.NUM_SUB(NS), .FAST_ROWS(F), .SLOW_ROWS(SR), .BEN_W(8), .MIG_EXTRA(E)) u_dut (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_wait(req_is_wait), .req_sub(req_sub), .req_row(req_row), .rsp_hit(rsp_hit),
    .rsp_row(rsp_row), .mig_busy(mig_busy), .cmd_valid(cmd_valid), .cmd_to_fast(cmd_to_fast),
    .cmd_sub(cmd_sub), .cmd_row(cmd_row)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model
  int m_vld [NS][F];
  int m_tag [NS][F];
  int m_ben [NS][F];
  int m_stamp [NS][F];
  int tick;
  int cur_pol;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic string pol_tag();
    if (cur_pol == 1) return "R5";
    if (cur_pol == 2) return "R6";
    return "R4";
  endfunction

  function automatic int pick(input int s);
    int best = 0;
    int key;
    int bkey;
    if (cur_pol == 2) begin
      bkey = m_vld[s][0] * 1000 + m_ben[s][0];
      for (int i = 1; i < F; i++) begin
        key = m_vld[s][i] * 1000 + m_ben[s][i];
        if (key < bkey) begin bkey = key; best = i; end
      end
    end else begin
      for (int i = 1; i < F; i++)
        if (m_stamp[s][i] < m_stamp[s][best]) best = i;
    end
    return best;
  endfunction

  task automatic bump(input int s, input int i);
    int v = m_ben[s][i] + 1;
    if (v == 255) begin
      for (int k = 0; k < F; k++) m_ben[s][k] = m_ben[s][k] / 2;
      m_ben[s][i] = 127;
    end else begin
      m_ben[s][i] = v;
    end
  endtask

  task automatic do_reset(input int pol);
    cur_pol = pol;
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    pol_sel = 2'(pol);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < F; i++) begin
        m_vld[s][i] = 0; m_tag[s][i] = 0; m_ben[s][i] = 0; m_stamp[s][i] = i;
      end
    tick = F;
    #1;
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "cmd_valid after reset", int'(cmd_valid), 0);
  endtask

  task automatic do_req(input bit opw, input int s, input int r, input string tg);
    bit ehit = 0;
    int eidx = 0;
    bit ins;
    int vic = 0;
    string htag = (tg == "") ? "R2" : tg;
    string ftag = (tg == "") ? pol_tag() : tg;
    for (int i = 0; i < F; i++)
      if (m_vld[s][i] != 0 && m_tag[s][i] == r) begin ehit = 1; eidx = i; end
    @(negedge clk);
    req_valid = 1'b1; req_is_wait = opw; req_sub = SUB_W'(s); req_row = SLOW_W'(r);
    #1;
    chk("R8", "ready before request", int'(req_ready), 1);
    chk(htag, "rsp_hit", int'(rsp_hit), int'(ehit));
    chk(htag, "rsp_row", int'(rsp_row), ehit ? eidx : F + r);
    ins = !ehit && (opw ? (cur_pol == 1 || cur_pol == 2) : (cur_pol != 1));
    if (ehit) begin
      bump(s, eidx);
      if (!opw) begin m_stamp[s][eidx] = tick; tick++; end
    end
    if (ins) begin
      vic = pick(s);
      m_vld[s][vic] = 1; m_tag[s][vic] = r; m_ben[s][vic] = 0;
      m_stamp[s][vic] = tick; tick++;
    end
    @(posedge clk);
    #1;
    if (!ins) begin
      req_valid = 1'b0;
      chk(ftag, "no fill: ready", int'(req_ready), 1);
      chk(ftag, "no fill: cmd_valid", int'(cmd_valid), 0);
    end else begin
      // hold a stray request while busy: it must not be taken
      req_is_wait = 1'b0; req_sub = SUB_W'(NS - 1); req_row = SLOW_W'(SR - 1);
      @(negedge clk);
      chk("R8", "src ready", int'(req_ready), 0);
      chk("R8", "src cmd_valid", int'(cmd_valid), 1);
      chk("R8", "src to_fast", int'(cmd_to_fast), 0);
      chk("R8", "src sub", int'(cmd_sub), s);
      chk("R8", "src row", int'(cmd_row), F + r);
      @(negedge clk);
      chk("R8", "dst cmd_valid", int'(cmd_valid), 1);
      chk("R8", "dst to_fast", int'(cmd_to_fast), 1);
      chk(ftag, "dst victim row", int'(cmd_row), vic);
      for (int k = 0; k < E; k++) begin
        @(negedge clk);
        chk("R8", "hold ready", int'(req_ready), 0);
        chk("R8", "hold cmd_valid", int'(cmd_valid), 0);
      end
      req_valid = 1'b0;
    end
  endtask

  initial begin
    int unsigned seed;
    int s, r;
    bit w;
    // R1 / R4: fresh fills go to fast rows 0..3 in order
    do_reset(0);
    for (int i = 0; i < F; i++) do_req(0, 0, i + 2, "R1");
    // R3 / R9 directed
    do_reset(0);
    do_req(0, 0, 7, "R9");
    do_req(0, 1, 7, "R3");
    do_req(0, 0, 7, "R9");
    do_req(0, 0, 8, "R4");
    do_req(0, 0, 9, "R4");
    do_req(0, 0, 10, "R4");
    do_req(0, 0, 11, "R4");
    do_req(0, 0, 7, "R9");
    // R5 directed: access misses never fill, wait reports do
    do_reset(1);
    do_req(0, 0, 3, "R5");
    do_req(1, 0, 3, "R5");
    do_req(0, 0, 3, "R5");
    do_req(1, 0, 3, "R5");
    // R7 directed: saturation halves the subarray in the same update
    do_reset(2);
    for (int i = 0; i < F; i++) do_req(0, 1, i, "R6");
    for (int k = 0; k < 4; k++) do_req(0, 1, 1, "R7");
    for (int k = 0; k < 5; k++) do_req(1, 1, 2, "R7");
    for (int k = 0; k < 6; k++) do_req(0, 1, 3, "R7");
    for (int k = 0; k < 255; k++) do_req(0, 1, 0, "R7");
    do_req(0, 1, 1, "R7");
    do_req(0, 1, 9, "R7");   // victim must be fast row 2
    do_req(0, 1, 2, "R9");   // evicted row misses
    // mixed sweeps over every policy
    for (int p = 0; p < 4; p++) begin
      do_reset(p);
      seed = 32'(p * 7919 + 17);
      for (int n = 0; n < 90; n++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        s = int'((seed >> 16) % NS);
        r = int'((seed >> 8) % 7);
        w = ((seed >> 24) & 3) == 0;
        do_req(w, s, r, "");
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule